// File: doc/BRIEF.md
# Load-Store Conflict Counting Filter

This block is a table of small saturating counters used by a load-store unit. It tracks loads that were sent to a queue with no address search and that issued without checking older stores. The table is indexed by the load or store address reduced modulo a prime table size (4001 by default). An issuing load raises its counter. The load lowers that counter again when it commits, or when it is flushed after issuing. A committing store probes its counter, and any nonzero value is a conservative hit: the surrounding core then squashes everything younger than the store. Address comparison for false hits and the squash logic itself sit outside this block.

Each of the four request ports (load issue, load commit, load flush, store probe) has its own valid/ready handshake and its own bit-serial modulo unit. The modulo unit holds one request at a time and delivers the table index a fixed number of cycles after acceptance. An increment that would push a counter past its maximum is refused, so the load must retry later. A load flagged as the oldest memory instruction passes without touching the table. After reset the table clears itself one entry per cycle, and all ports hold ready low until the clear is done.

Top module: `ldst_conflict_filter`

## Requirements
- R1: After reset every counter is cleared by a sweep of one entry per clock (TABLE_SIZE cycles), all four ready outputs stay low until the sweep ends, and a later probe of any address returns hit=0, count=0.
- R2: The entry used is the address modulo TABLE_SIZE (4001 by default), so addresses that differ by a multiple of TABLE_SIZE share one counter, and an address with all 32 bits set maps to entry 4294967295 mod 4001.
- R3: An accepted issue request whose oldest flag is 0 and whose counter is below its maximum raises that counter by one and answers with ok=1.
- R4: An issue request whose counter is already at the maximum (15 for 4-bit counters), with no decrement to that entry in the same table cycle, is refused with ok=0 and leaves the counter unchanged.
- R5: An issue request with the oldest flag set answers ok=1 and changes no counter, even when the counter is at its maximum.
- R6: A commit or a flush request lowers its counter by one, and a commit and a flush that reach the same entry in the same table cycle lower it by two.
- R7: A probe answers hit=1 with the counter value when the counter is nonzero and hit=0, count=0 when it is zero, and it reports the value held before any update that reaches the same entry in the same table cycle.
- R8: An increment and a decrement that reach the same entry in the same table cycle cancel: the counter keeps its value and the increment answers ok=1, even at the maximum.
- R9: With the default bit-serial modulo and 32-bit addresses, a response (or the return of ready on a decrement port) follows ADDR_W+1 = 33 clock edges after the accepting edge, and a port holds ready low from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Load issue request valid |
| iss_ready | output | 1 | Issue port can accept a request |
| iss_addr | input | ADDR_W | Address of the issuing load |
| iss_oldest | input | 1 | Load is the oldest memory instruction and skips the table |
| iss_rsp_valid | output | 1 | Issue answer valid, one-cycle pulse |
| iss_rsp_ok | output | 1 | 1 = counted or skipped, 0 = refused, retry later |
| cmt_valid | input | 1 | Load commit decrement valid |
| cmt_ready | output | 1 | Commit port can accept a request |
| cmt_addr | input | ADDR_W | Address of the committing load |
| fls_valid | input | 1 | Flushed load decrement valid |
| fls_ready | output | 1 | Flush port can accept a request |
| fls_addr | input | ADDR_W | Address of the flushed load |
| prb_valid | input | 1 | Store probe valid |
| prb_ready | output | 1 | Probe port can accept a request |
| prb_addr | input | ADDR_W | Address of the committing store |
| prb_rsp_valid | output | 1 | Probe answer valid, one-cycle pulse |
| prb_hit | output | 1 | Counter was nonzero |
| prb_count | output | CNT_W | Counter value seen by the probe |

## Verification
An increment, one or two decrements and a probe can all reach the same counter in one table cycle. The bench provokes this by raising the valids of several ports on the same clock edge, so the equal-latency modulo units deliver their indices together. It checks the cancel case at a full counter (ok=1, count kept at 15), the double decrement (count drops by two), and a probe racing an increment: the probe must report the value from before the increment, and a follow-up probe must show the raised value.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
   // Variant of the address-to-index reduction.
   typedef enum logic {
      HASH_SEQ  = 1'b0,  // one address bit per cycle, restoring remainder
      HASH_COMB = 1'b1   // single-cycle modulo operator
   } hash_style_e;

   // Number of decrement sources feeding the table (commit, flush).
   localparam int NUM_DEC = 2;
endpackage

// File: rtl/cbf_hash.sv
module cbf_hash #(
   parameter int ADDR_W     = 32,
   parameter int TABLE_SIZE = 4001,
   parameter int IDX_W      = $clog2(TABLE_SIZE),
   parameter cbf_pkg::hash_style_e HASH_STYLE = cbf_pkg::HASH_SEQ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              idx_valid_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam logic [IDX_W:0] MODV = (IDX_W+1)'(TABLE_SIZE);

   logic accept;
   assign accept = req_valid_i && req_ready_o;

   generate
      if (HASH_STYLE == cbf_pkg::HASH_SEQ) begin : g_seq
         localparam int CW = $clog2(ADDR_W + 1);
         logic              busy_q, done_q;
         logic [ADDR_W-1:0] sh_q;
         logic [CW-1:0]     cnt_q;
         logic [IDX_W-1:0]  rem_q;
         logic [IDX_W:0]    trial;
         logic [IDX_W-1:0]  rem_nxt;

         // Shift one address bit into the remainder and subtract once.
         always_comb begin
            trial   = {rem_q, sh_q[ADDR_W-1]};
            rem_nxt = (trial >= MODV) ? IDX_W'(trial - MODV) : IDX_W'(trial);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               done_q <= 1'b0;
               sh_q   <= '0;
               cnt_q  <= '0;
               rem_q  <= '0;
            end else if (accept) begin
               busy_q <= 1'b1;
               sh_q   <= req_addr_i;
               cnt_q  <= CW'(ADDR_W);
               rem_q  <= '0;
            end else if (busy_q) begin
               rem_q <= rem_nxt;
               sh_q  <= sh_q << 1;
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else if (done_q) begin
               done_q <= 1'b0;
            end
         end

         assign req_ready_o = en_i && !busy_q && !done_q;
         assign idx_valid_o = done_q;
         assign idx_o       = rem_q;
      end else begin : g_comb
         logic             done_q;
         logic [IDX_W-1:0] idx_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               idx_q  <= '0;
            end else if (accept) begin
               done_q <= 1'b1;
               idx_q  <= IDX_W'(req_addr_i % ADDR_W'(TABLE_SIZE));
            end else begin
               done_q <= 1'b0;
            end
         end

         assign req_ready_o = en_i && !done_q;
         assign idx_valid_o = done_q;
         assign idx_o       = idx_q;
      end
   endgenerate

   // R2: every index handed to the table lies inside it
   a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid_o |-> ({1'b0, idx_o} < MODV));

   // R9: one request at a time, ready drops after acceptance
   a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready_o);
endmodule

// File: rtl/cbf_table.sv
module cbf_table #(
   parameter int TABLE_SIZE = 4001,
   parameter int CNT_W      = 4,
   parameter int IDX_W      = $clog2(TABLE_SIZE)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   output logic                                 init_done_o,
   input  logic                                 inc_v_i,
   input  logic                                 inc_byp_i,
   input  logic [IDX_W-1:0]                     inc_idx_i,
   input  logic [cbf_pkg::NUM_DEC-1:0]          dec_v_i,
   input  logic [cbf_pkg::NUM_DEC-1:0][IDX_W-1:0] dec_idx_i,
   input  logic                                 prb_v_i,
   input  logic [IDX_W-1:0]                     prb_idx_i,
   output logic                                 inc_rsp_v_o,
   output logic                                 inc_rsp_ok_o,
   output logic                                 prb_rsp_v_o,
   output logic                                 prb_hit_o,
   output logic [CNT_W-1:0]                     prb_cnt_o
);
   localparam int ND = cbf_pkg::NUM_DEC;
   localparam int SW = CNT_W + 2;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] tbl [TABLE_SIZE];
   logic [IDX_W-1:0] clr_ptr;

   logic [CNT_W-1:0]         rd_inc, rd_prb;
   logic [ND-1:0][CNT_W-1:0] rd_dec, new_dec;
   logic [1:0]               n_inc;
   logic                     inc_go, inc_take;
   logic [SW-1:0]            sum_inc;
   logic [CNT_W-1:0]         new_inc;
   logic [ND-1:0]            under;

   // Net update per touched entry: old value plus accepted increment
   // minus every decrement that lands on the same entry this cycle.
   always_comb begin
      rd_inc = tbl[inc_idx_i];
      rd_prb = tbl[prb_idx_i];
      inc_go = inc_v_i && !inc_byp_i;
      n_inc  = '0;
      for (int k = 0; k < ND; k++)
         n_inc = n_inc + 2'(dec_v_i[k] && (dec_idx_i[k] == inc_idx_i));
      inc_take = inc_go && ((rd_inc != CNT_MAX) || (n_inc != 2'd0));
      sum_inc  = {2'b00, rd_inc} + SW'(1);
      new_inc  = (sum_inc < SW'(n_inc)) ? '0 : CNT_W'(sum_inc - SW'(n_inc));
      for (int k = 0; k < ND; k++) begin
         logic [1:0]    n_k;
         logic [SW-1:0] sum_k;
         rd_dec[k] = tbl[dec_idx_i[k]];
         n_k = '0;
         for (int j = 0; j < ND; j++)
            n_k = n_k + 2'(dec_v_i[j] && (dec_idx_i[j] == dec_idx_i[k]));
         sum_k = {2'b00, rd_dec[k]} + SW'(inc_take && (inc_idx_i == dec_idx_i[k]));
         under[k]   = dec_v_i[k] && (sum_k < SW'(n_k));
         new_dec[k] = (sum_k < SW'(n_k)) ? '0 : CNT_W'(sum_k - SW'(n_k));
      end
   end

   // Counter storage: swept to zero after reset, then updated by requests.
   always_ff @(posedge clk) begin
      if (!init_done_o) begin
         tbl[clr_ptr] <= '0;
      end else begin
         if (inc_take) tbl[inc_idx_i] <= new_inc;
         for (int k = 0; k < ND; k++)
            if (dec_v_i[k]) tbl[dec_idx_i[k]] <= new_dec[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_done_o  <= 1'b0;
         clr_ptr      <= '0;
         inc_rsp_v_o  <= 1'b0;
         inc_rsp_ok_o <= 1'b0;
         prb_rsp_v_o  <= 1'b0;
         prb_hit_o    <= 1'b0;
         prb_cnt_o    <= '0;
      end else begin
         if (!init_done_o) begin
            if (clr_ptr == IDX_W'(TABLE_SIZE - 1)) init_done_o <= 1'b1;
            else                                   clr_ptr     <= clr_ptr + 1'b1;
         end
         inc_rsp_v_o  <= inc_v_i;
         inc_rsp_ok_o <= inc_byp_i || inc_take;
         prb_rsp_v_o  <= prb_v_i;
         prb_hit_o    <= (rd_prb != '0);
         prb_cnt_o    <= rd_prb;
      end
   end

   // R1: no request reaches the table while it is being cleared
   a_r1_quiet_during_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done_o |-> !(inc_v_i || prb_v_i || (|dec_v_i)));

   // R4: a full counter with no same-cycle decrement refuses the load
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v_i && !inc_byp_i && rd_inc == CNT_MAX && n_inc == 2'd0)
      |=> (inc_rsp_v_o && !inc_rsp_ok_o));

   // R7: probe reports the value held before this cycle's updates
   a_r7_probe_old_value: assert property (@(posedge clk) disable iff (!rst_n)
      prb_v_i |=> (prb_rsp_v_o && prb_cnt_o == $past(rd_prb)
                   && prb_hit_o == (prb_cnt_o != '0)));

   generate
      for (genvar g = 0; g < ND; g++) begin : g_dec_chk
         // R6: a decrement never takes a counter below zero
         a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            dec_v_i[g] |-> !under[g]);
      end
   endgenerate
endmodule

// File: rtl/ldst_conflict_filter.sv
module ldst_conflict_filter #(
   parameter int ADDR_W     = 32,
   parameter int TABLE_SIZE = 4001,
   parameter int CNT_W      = 4,
   parameter cbf_pkg::hash_style_e HASH_STYLE = cbf_pkg::HASH_SEQ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic              iss_oldest,
   output logic              iss_rsp_valid,
   output logic              iss_rsp_ok,
   input  logic              cmt_valid,
   output logic              cmt_ready,
   input  logic [ADDR_W-1:0] cmt_addr,
   input  logic              fls_valid,
   output logic              fls_ready,
   input  logic [ADDR_W-1:0] fls_addr,
   input  logic              prb_valid,
   output logic              prb_ready,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic              prb_rsp_valid,
   output logic              prb_hit,
   output logic [CNT_W-1:0]  prb_count
);
   localparam int IDX_W = $clog2(TABLE_SIZE);
   localparam int ND    = cbf_pkg::NUM_DEC;

   initial begin
      assert (TABLE_SIZE > 1) else $error("table needs at least two entries");
      assert (CNT_W >= 2)     else $error("counters need at least two bits");
      assert (ADDR_W >= IDX_W) else $error("address narrower than index");
   end

   logic init_done;
   logic byp_q;
   logic iss_iv, cmt_iv, fls_iv, prb_iv;
   logic [IDX_W-1:0] iss_idx, cmt_idx, fls_idx, prb_idx;
   logic [ND-1:0]            dec_v;
   logic [ND-1:0][IDX_W-1:0] dec_idx;

   // Oldest-load flag travels alongside the single in-flight issue request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       byp_q <= 1'b0;
      else if (iss_valid && iss_ready)  byp_q <= iss_oldest;
   end

   cbf_hash #(.ADDR_W(ADDR_W), .TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W),
              .HASH_STYLE(HASH_STYLE)) u_hash_iss (
      .clk(clk), .rst_n(rst_n), .en_i(init_done),
      .req_valid_i(iss_valid), .req_ready_o(iss_ready), .req_addr_i(iss_addr),
      .idx_valid_o(iss_iv), .idx_o(iss_idx));

   cbf_hash #(.ADDR_W(ADDR_W), .TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W),
              .HASH_STYLE(HASH_STYLE)) u_hash_cmt (
      .clk(clk), .rst_n(rst_n), .en_i(init_done),
      .req_valid_i(cmt_valid), .req_ready_o(cmt_ready), .req_addr_i(cmt_addr),
      .idx_valid_o(cmt_iv), .idx_o(cmt_idx));

   cbf_hash #(.ADDR_W(ADDR_W), .TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W),
              .HASH_STYLE(HASH_STYLE)) u_hash_fls (
      .clk(clk), .rst_n(rst_n), .en_i(init_done),
      .req_valid_i(fls_valid), .req_ready_o(fls_ready), .req_addr_i(fls_addr),
      .idx_valid_o(fls_iv), .idx_o(fls_idx));

   cbf_hash #(.ADDR_W(ADDR_W), .TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W),
              .HASH_STYLE(HASH_STYLE)) u_hash_prb (
      .clk(clk), .rst_n(rst_n), .en_i(init_done),
      .req_valid_i(prb_valid), .req_ready_o(prb_ready), .req_addr_i(prb_addr),
      .idx_valid_o(prb_iv), .idx_o(prb_idx));

   assign dec_v   = {fls_iv, cmt_iv};
   assign dec_idx = {fls_idx, cmt_idx};

   cbf_table #(.TABLE_SIZE(TABLE_SIZE), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .init_done_o(init_done),
      .inc_v_i(iss_iv), .inc_byp_i(byp_q), .inc_idx_i(iss_idx),
      .dec_v_i(dec_v), .dec_idx_i(dec_idx),
      .prb_v_i(prb_iv), .prb_idx_i(prb_idx),
      .inc_rsp_v_o(iss_rsp_valid), .inc_rsp_ok_o(iss_rsp_ok),
      .prb_rsp_v_o(prb_rsp_valid), .prb_hit_o(prb_hit), .prb_cnt_o(prb_count));
endmodule

// File: tb/tb_ldst_conflict_filter.sv
module tb_ldst_conflict_filter;
   localparam int ADDR_W = 32;
   localparam int TSIZE  = 4001;
   localparam int CNT_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic iss_valid = 0, iss_oldest = 0, cmt_valid = 0, fls_valid = 0, prb_valid = 0;
   logic [ADDR_W-1:0] iss_addr = '0, cmt_addr = '0, fls_addr = '0, prb_addr = '0;
   logic iss_ready, cmt_ready, fls_ready, prb_ready;
   logic iss_rsp_valid, iss_rsp_ok, prb_rsp_valid, prb_hit;
   logic [CNT_W-1:0] prb_count;

   ldst_conflict_filter dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
      .iss_oldest(iss_oldest), .iss_rsp_valid(iss_rsp_valid), .iss_rsp_ok(iss_rsp_ok),
      .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_addr(cmt_addr),
      .fls_valid(fls_valid), .fls_ready(fls_ready), .fls_addr(fls_addr),
      .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr),
      .prb_rsp_valid(prb_rsp_valid), .prb_hit(prb_hit), .prb_count(prb_count));

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   logic r_ok, r_hit;
   logic [CNT_W-1:0] r_cnt;
   int r_lat;

   // Vector: {op, address, expect}. op 0 issue (expect[0]=ok),
   // 1 commit, 2 flush, 3 probe (expect = {hit, count}).
   localparam int NV = 14;
   localparam logic [38:0] VEC [NV] = '{
      {2'd3, 32'd100,  5'h00}, {2'd0, 32'd100,  5'h01}, {2'd0, 32'd4101, 5'h01},
      {2'd3, 32'd100,  5'h12}, {2'd3, 32'd8102, 5'h12}, {2'd3, 32'd101,  5'h00},
      {2'd0, 32'd7,    5'h01}, {2'd1, 32'd100,  5'h00}, {2'd3, 32'd4101, 5'h11},
      {2'd2, 32'd4101, 5'h00}, {2'd3, 32'd100,  5'h00}, {2'd3, 32'd7,    5'h11},
      {2'd1, 32'd7,    5'h00}, {2'd3, 32'd7,    5'h00}};

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // Launch any mix of ports on one edge and wait until all have finished.
   task automatic go(input bit ui, input bit uc, input bit uf, input bit up,
                     input logic [31:0] ai, input logic [31:0] ac,
                     input logic [31:0] af, input logic [31:0] ap, input bit byp);
      bit gi, gp, all;
      int n;
      @(negedge clk);
      while ((ui && !iss_ready) || (uc && !cmt_ready) ||
             (uf && !fls_ready) || (up && !prb_ready)) @(negedge clk);
      iss_valid = ui; iss_addr = ai; iss_oldest = byp;
      cmt_valid = uc; cmt_addr = ac;
      fls_valid = uf; fls_addr = af;
      prb_valid = up; prb_addr = ap;
      @(negedge clk);
      iss_valid = 0; cmt_valid = 0; fls_valid = 0; prb_valid = 0; iss_oldest = 0;
      n = 1; gi = !ui; gp = !up;
      forever begin
         if (iss_rsp_valid) begin gi = 1; r_ok = iss_rsp_ok; end
         if (prb_rsp_valid) begin gp = 1; r_hit = prb_hit; r_cnt = prb_count; end
         all = gi && gp && (!uc || cmt_ready) && (!uf || fls_ready);
         if (all) break;
         @(negedge clk);
         n++;
      end
      r_lat = n - 1;
   endtask

   task automatic probe_chk(input string rq, input logic [31:0] a,
                            input logic hit, input int cnt);
      go(0, 0, 0, 1, 0, 0, 0, a, 0);
      chk(rq, "probe hit", 32'(r_hit), 32'(hit));
      chk(rq, "probe count", 32'(r_cnt), 32'(cnt));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      finish_run();
   end

   initial begin
      int clr;
      int refc [3];
      logic [31:0] raddr [4];
      int rslot [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: readies low during the clear sweep, released after TABLE_SIZE edges
      chk("R1", "iss_ready at start", 32'(iss_ready), 0);
      chk("R1", "prb_ready at start", 32'(prb_ready), 0);
      clr = 1;
      while (!iss_ready && clr < TSIZE + 10) begin @(negedge clk); clr++; end
      chk("R1", "sweep length ok", 32'(clr >= TSIZE && clr <= TSIZE + 1), 1);

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [31:0] a;
         logic [4:0]  e;
         {op, a, e} = VEC[v];
         case (op)
            2'd0: begin
               go(1, 0, 0, 0, a, 0, 0, 0, 0);
               chk("R3", $sformatf("vector %0d issue ok", v), 32'(r_ok), 32'(e[0]));
            end
            2'd1: go(0, 1, 0, 0, 0, a, 0, 0, 0);   // R6 commit, judged by later probe
            2'd2: go(0, 0, 1, 0, 0, 0, a, 0, 0);   // R6 flush, judged by later probe
            default: begin
               go(0, 0, 0, 1, 0, 0, 0, a, 0);
               chk("R7", $sformatf("vector %0d probe hit", v), 32'(r_hit), 32'(e[4]));
               chk("R2", $sformatf("vector %0d probe count", v), 32'(r_cnt), 32'(e[3:0]));
            end
         endcase
      end

      // R2: top address reduces to its remainder; R9: bit-serial latency
      go(1, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
      chk("R9", "issue latency", 32'(r_lat), 32'(ADDR_W + 1));
      probe_chk("R2", 32'hFFFF_FFFF % TSIZE, 1, 1);
      go(0, 1, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
      chk("R9", "commit latency", 32'(r_lat), 32'(ADDR_W + 1));

      // R4: fill entry 500 to 15, the sixteenth issue is refused
      for (int i = 0; i < 15; i++) begin
         go(1, 0, 0, 0, 32'd500, 0, 0, 0, 0);
         chk("R3", $sformatf("fill step %0d ok", i), 32'(r_ok), 1);
      end
      go(1, 0, 0, 0, 32'd4501, 0, 0, 0, 0);
      chk("R4", "issue at max refused", 32'(r_ok), 0);
      probe_chk("R4", 32'd500, 1, 15);

      // R5: oldest load skips the table even when full
      go(1, 0, 0, 0, 32'd500, 0, 0, 0, 1);
      chk("R5", "oldest load ok", 32'(r_ok), 1);
      probe_chk("R5", 32'd500, 1, 15);
      go(1, 0, 0, 0, 32'd600, 0, 0, 0, 1);
      probe_chk("R5", 32'd600, 0, 0);

      // R8: same-cycle increment and commit on a full entry cancel
      go(1, 1, 0, 0, 32'd500, 32'd4501, 0, 0, 0);
      chk("R8", "cancel issue ok", 32'(r_ok), 1);
      probe_chk("R8", 32'd500, 1, 15);

      // R6: commit and flush on one entry in one cycle lower it by two
      go(0, 1, 1, 0, 0, 32'd500, 32'd4501, 0, 0);
      probe_chk("R6", 32'd500, 1, 13);

      // R7: probe racing an increment sees the old value
      go(1, 0, 0, 1, 32'd500, 0, 0, 32'd8502, 0);
      chk("R7", "race probe count", 32'(r_cnt), 13);
      chk("R3", "race issue ok", 32'(r_ok), 1);
      probe_chk("R7", 32'd500, 1, 14);

      // Random traffic against a reference count, with aliasing addresses
      raddr = '{32'd900, 32'd4901, 32'd1234, 32'd77777};
      rslot = '{0, 0, 1, 2};
      refc  = '{0, 0, 0};
      void'($urandom(32'd7));
      for (int t = 0; t < 70; t++) begin
         int s, op;
         s  = $urandom_range(0, 3);
         op = $urandom_range(0, 3);
         if (op == 0) begin
            go(1, 0, 0, 0, raddr[s], 0, 0, 0, 0);
            chk(refc[rslot[s]] < 15 ? "R3" : "R4", "random issue ok",
                32'(r_ok), 32'(refc[rslot[s]] < 15));
            if (refc[rslot[s]] < 15) refc[rslot[s]]++;
         end else if (op != 3 && refc[rslot[s]] > 0) begin
            if (op == 1) go(0, 1, 0, 0, 0, raddr[s], 0, 0, 0);
            else         go(0, 0, 1, 0, 0, 0, raddr[s], 0, 0);
            refc[rslot[s]]--;                      // R6
         end else begin
            probe_chk("R7", raddr[s], refc[rslot[s]] != 0, refc[rslot[s]]);
         end
      end
      for (int s = 0; s < 4; s++)
         probe_chk("R2", raddr[s], refc[rslot[s]] != 0, refc[rslot[s]]);

      finish_run();
   end
endmodule